// File: doc/BRIEF.md
# Prescaled Period Timer with Watchdog Mode

This block is a countdown timer channel built from two cascaded 16-bit down counters. The upper half of a single 32-bit count register sets a clock divider and the lower half sets how many divided ticks make one period. Software writes a mode register to start and stop the channel, to pick one-shot or free-running operation, and to enable the expiry interrupt. In timer mode every expiry sets a sticky status flag and can pulse an interrupt line.

The same channel can be turned into a watchdog. In that mode an expiry raises a reset request that stays high until the block is reset, and no interrupt or status flag is produced. Software keeps the watchdog from firing by writing the key byte 0xA5 into the top byte of the mode register, which restarts the countdown from the full period. While the watchdog is running, a write that clears only the run bit is refused. A write that clears both the run bit and the watchdog bit does stop it, unless the block is built with the `LOCK` parameter set, in which case nothing stops it.

The control sequencer has four states. IDLE means stopped with the run bit clear or not yet reloaded. RUN means counting. DONE means a one-shot period has ended. BITE means the watchdog has fired and the block is terminal.

Transitions:
- IDLE→RUN on a reload while the run bit is set.
- RUN→RUN (restart) on a reload or a service.
- RUN→RUN (wrap) on a timer expiry in continuous mode.
- RUN→DONE on a timer expiry in one-shot mode.
- RUN→BITE on a watchdog expiry.
- RUN→IDLE and DONE→IDLE when the run bit is cleared.
- DONE→RUN on a reload.

Top module: `ptw_timer`

## Requirements
- R1: After reset, `irq_o`, `expired_o`, `reset_req_o` and `busy_o` are all 0.
- R2: With the count register holding divider P in bits [31:16] and count C in bits [15:0], the first expiry comes P×C clocks after the reload edge. In continuous mode (mode bit 10 set), further expiries follow every P×C clocks. `irq_o` is high in the cycle after the edge that ends the period.
- R3: A divider field of 0 divides by 65536.
- R4: With mode bit 10 clear, the timer expires once and then stops, and `busy_o` drops.
- R5: Clearing the run bit (mode bit 12) stops counting: `busy_o` falls and no further expiry occurs.
- R6: A timer-mode expiry sets the status flag (`expired_o`, status bit 0). `irq_o` pulses for one cycle only when mode bit 8 is set. Writing 1 to status bit 0 clears the flag.
- R7: A write to the count register, or a 0→1 change of the run bit, reloads both counters. The period restarts one cycle after the write edge.
- R8: With mode bit 15 set, expiry raises `reset_req_o`, which stays high until reset. Such an expiry produces no interrupt and no status flag.
- R9: Writing 0xA5 to mode bits [31:24] while the watchdog runs restarts the full period. Any other byte value there has no effect.
- R10: While the watchdog runs, a mode write that clears bit 12 but not bit 15 leaves both set. A write clearing both stops the channel when `LOCK` is 0.
- R11: With `LOCK` set to 1, even a write clearing both bits leaves the watchdog running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 count, 2 status |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| irq_o | output | 1 | One-cycle expiry interrupt pulse |
| expired_o | output | 1 | Sticky timer expiry flag |
| reset_req_o | output | 1 | Sticky watchdog reset request |
| busy_o | output | 1 | Sequencer is in the RUN state |

## Verification
The period is tried with three divider/count pairs: 3×4 free-running, 2×5 one-shot, and 1×7 restarted mid-period. These separate errors in the divider from errors in the count, and show whether a restart discards the partial period. A single-tick count with a zero divider isolates the 65536 wrap case. The watchdog runs are paired so that a keyed service, a wrong key, a lone run-bit clear and a full release each shift or suppress the bite cycle in a different, predictable way. A second instance built with the lock on shows the release being refused.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_BITE = 2'd3
    } ptw_state_e;

    typedef enum logic [1:0] {
        A_MODE   = 2'd0,
        A_COUNT  = 2'd1,
        A_STATUS = 2'd2
    } ptw_addr_e;

    localparam int unsigned MB_IRQ_EN = 8;
    localparam int unsigned MB_CONT   = 10;
    localparam int unsigned MB_RUN    = 12;
    localparam int unsigned MB_WDT    = 15;
    localparam int unsigned KEY_LSB   = 24;
    localparam logic [7:0]  SERVICE_KEY = 8'hA5;

    typedef struct packed {
        logic wdt;
        logic run;
        logic cont;
        logic irq_en;
    } ptw_mode_t;

endpackage

// File: rtl/ptw_dcount.sv
module ptw_dcount #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] top;

    // a field of 0 wraps to all ones, giving 2**W steps
    assign top    = div_i - W'(1);
    assign tick_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= top;
        end else if (run_i) begin
            cnt_q <= (cnt_q == '0) ? top : cnt_q - W'(1);
        end
    end
endmodule

// File: rtl/ptw_regs.sv
module ptw_regs
    import ptw_pkg::*;
#(
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 16,
    parameter bit          LOCK    = 1'b0,
    localparam int unsigned REG_W  = PRESC_W + CNT_W,
    localparam int unsigned BE_W   = REG_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [BE_W-1:0]    wr_be,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               tmr_exp_i,
    output ptw_mode_t          mode_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               reload_o,
    output logic               service_o,
    output logic               flag_o
);
    ptw_mode_t          mode_q, mode_d, cand;
    logic [REG_W-1:0]   word_q, word_d;
    logic               reload_q, service_q, flag_q;
    logic               mode_wr, cnt_wr, stat_wr;
    logic               wdt_act, release_ok;

    assign mode_wr = wr_en && (wr_addr == A_MODE);
    assign cnt_wr  = wr_en && (wr_addr == A_COUNT);
    assign stat_wr = wr_en && (wr_addr == A_STATUS);
    assign wdt_act = mode_q.wdt && mode_q.run;

    assign cand.wdt    = wr_data[MB_WDT];
    assign cand.run    = wr_data[MB_RUN];
    assign cand.cont   = wr_data[MB_CONT];
    assign cand.irq_en = wr_data[MB_IRQ_EN];

    assign release_ok = mode_wr && wr_be[1] && !cand.run && !cand.wdt && !LOCK;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr && wr_be[1]) begin
            mode_d = cand;
            if (wdt_act && !release_ok) begin
                mode_d.run = 1'b1;
                mode_d.wdt = 1'b1;
            end
        end
    end

    always_comb begin
        word_d = word_q;
        for (int i = 0; i < int'(BE_W); i++) begin
            if (cnt_wr && wr_be[i]) begin
                word_d[i*8 +: 8] = wr_data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            word_q    <= '0;
            reload_q  <= 1'b0;
            service_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            word_q    <= word_d;
            reload_q  <= (cnt_wr && (wr_be != '0)) || (mode_d.run && !mode_q.run);
            service_q <= mode_wr && wr_be[BE_W-1] && wdt_act &&
                         (wr_data[KEY_LSB +: 8] == SERVICE_KEY);
            if (tmr_exp_i) begin
                flag_q <= 1'b1;
            end else if (stat_wr && wr_be[0] && wr_data[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign mode_o    = mode_q;
    assign presc_o   = word_q[REG_W-1 -: PRESC_W];
    assign cnt_o     = word_q[CNT_W-1:0];
    assign reload_o  = reload_q;
    assign service_o = service_q;
    assign flag_o    = flag_q;

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_act && !release_ok) |=> (mode_q.run && mode_q.wdt));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_exp_i |=> flag_q);
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
    import ptw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ptw_mode_t mode_i,
    input  logic      reload_i,
    input  logic      service_i,
    input  logic      expire_i,
    output logic      load_o,
    output logic      run_o,
    output logic      tmr_exp_o,
    output logic      irq_o,
    output logic      rstreq_o,
    output logic      busy_o
);
    ptw_state_e state_q, state_d;
    logic       irq_q, rstreq_q;
    logic       wdt_exp;

    assign load_o    = (state_q != ST_BITE) && mode_i.run &&
                       (reload_i || (service_i && state_q == ST_RUN));
    assign run_o     = (state_q == ST_RUN) && mode_i.run && !load_o;
    assign tmr_exp_o = expire_i && !mode_i.wdt;
    assign wdt_exp   = expire_i && mode_i.wdt;
    assign busy_o    = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (mode_i.run && reload_i) state_d = ST_RUN;
            ST_RUN: begin
                if (!mode_i.run)                state_d = ST_IDLE;
                else if (reload_i || service_i) state_d = ST_RUN;
                else if (expire_i) begin
                    if (mode_i.wdt)       state_d = ST_BITE;
                    else if (mode_i.cont) state_d = ST_RUN;
                    else                  state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!mode_i.run)   state_d = ST_IDLE;
                else if (reload_i) state_d = ST_RUN;
            end
            ST_BITE: state_d = ST_BITE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q    <= 1'b0;
            rstreq_q <= 1'b0;
        end else begin
            irq_q    <= tmr_exp_o && mode_i.irq_en;
            rstreq_q <= rstreq_q || wdt_exp;
        end
    end

    assign irq_o    = irq_q;
    assign rstreq_o = rstreq_q;

    // R8
    bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rstreq_q |=> rstreq_q);

    // R8
    wdt_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i.wdt |=> !irq_q);

    // R5
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i.run |=> !busy_o);

    // R6
    irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(mode_i.irq_en));
endmodule

// File: rtl/ptw_timer.sv
module ptw_timer
    import ptw_pkg::*;
#(
    parameter int unsigned PRESC_W = 16,
    parameter int unsigned CNT_W   = 16,
    parameter bit          LOCK    = 1'b0,
    localparam int unsigned REG_W  = PRESC_W + CNT_W,
    localparam int unsigned BE_W   = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic             irq_o,
    output logic             expired_o,
    output logic             reset_req_o,
    output logic             busy_o
);
    ptw_mode_t          mode;
    logic [PRESC_W-1:0] presc;
    logic [CNT_W-1:0]   cnt;
    logic reload, service, load, run, presc_tick, expire, tmr_exp;

    ptw_regs #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .LOCK(LOCK)) u_regs (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_be, .wr_data,
        .tmr_exp_i(tmr_exp), .mode_o(mode), .presc_o(presc), .cnt_o(cnt),
        .reload_o(reload), .service_o(service), .flag_o(expired_o)
    );

    ptw_dcount #(.W(PRESC_W)) u_presc (
        .clk, .rst_n, .load_i(load), .run_i(run), .div_i(presc), .tick_o(presc_tick)
    );

    ptw_dcount #(.W(CNT_W)) u_count (
        .clk, .rst_n, .load_i(load), .run_i(presc_tick), .div_i(cnt), .tick_o(expire)
    );

    ptw_seq u_seq (
        .clk, .rst_n, .mode_i(mode), .reload_i(reload), .service_i(service),
        .expire_i(expire), .load_o(load), .run_o(run), .tmr_exp_o(tmr_exp),
        .irq_o, .rstreq_o(reset_req_o), .busy_o
    );

    // R6
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> expired_o);
endmodule

// File: tb/ptw_timer_tb.sv
module ptw_timer_tb;
    import ptw_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_en_lk = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic irq, expired, rstreq, busy;
    logic lk_irq, lk_expired, lk_rstreq, lk_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_timer u_dut (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_be, .wr_data,
        .irq_o(irq), .expired_o(expired), .reset_req_o(rstreq), .busy_o(busy)
    );

    ptw_timer #(.LOCK(1'b1)) u_dut_lk (
        .clk, .rst_n, .wr_en(wr_en_lk), .wr_addr, .wr_be, .wr_data,
        .irq_o(lk_irq), .expired_o(lk_expired), .reset_req_o(lk_rstreq), .busy_o(lk_busy)
    );

    int    cyc = 0;
    int    n_tests = 0, n_fail = 0;
    int    exp_q[$];
    int    exp_rst = -1;
    bit    rst_seen = 1'b0;
    string cur_tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input bit lk, input logic [1:0] a, input logic [3:0] be,
                      input logic [31:0] d, output int w);
        @(negedge clk);
        wr_addr = a; wr_be = be; wr_data = d;
        if (lk) wr_en_lk = 1'b1; else wr_en = 1'b1;
        w = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0; wr_en_lk = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // scoreboard monitor: pops expected expiry cycles as pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) begin
                if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected irq"}, cyc, -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, {cur_tag, " irq cycle"}, cyc, e);
                end
            end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
                chk(1'b0, {cur_tag, " missed irq"}, cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (rstreq && !rst_seen) begin
                rst_seen = 1'b1;
                chk(cyc == exp_rst, "R8 bite cycle", cyc, exp_rst);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int w, w2, wc, wd, ws, wn, wl, wx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 0 && expired == 0 && rstreq == 0 && busy == 0, "R1 reset outputs",
            {irq, expired, rstreq, busy}, 0);

        // R2 continuous 3x4
        cur_tag = "R2";
        wr(0, A_COUNT, 4'hF, 32'h0003_0004, w);
        wr(0, A_MODE, 4'hF, 32'h0000_1500, w);
        exp_q.push_back(w + 13); exp_q.push_back(w + 25); exp_q.push_back(w + 37);
        wait_until(w + 40);
        cur_tag = "R5";
        wr(0, A_MODE, 4'hF, 32'h0, w2);
        wait_until(w2 + 1);
        chk(busy == 0, "R5 busy after stop", busy, 0);
        wait_until(w + 56);
        chk(expired == 1, "R6 flag set", expired, 1);
        wr(0, A_STATUS, 4'h1, 32'h1, w2);
        chk(expired == 0, "R6 flag cleared", expired, 0);

        // R4 one-shot 2x5
        cur_tag = "R4";
        wr(0, A_COUNT, 4'hF, 32'h0002_0005, w);
        wr(0, A_MODE, 4'hF, 32'h0000_1100, w);
        exp_q.push_back(w + 11);
        wait_until(w + 14);
        chk(busy == 0, "R4 stopped after one expiry", busy, 0);
        wait_until(w + 30);

        // R7 reload by count write, restarted mid-period
        cur_tag = "R7";
        wr(0, A_COUNT, 4'hF, 32'h0001_0007, wc);
        wait_until(wc + 3);
        wr(0, A_COUNT, 4'hF, 32'h0001_0007, wd);
        exp_q.push_back(wd + 8);
        wait_until(wd + 12);
        chk(busy == 0, "R7 one-shot ended", busy, 0);
        chk(exp_q.size() == 0, "R7 restart expiry seen", exp_q.size(), 0);
        wr(0, A_STATUS, 4'h1, 32'h1, w2);

        // R6 interrupt disabled: flag only
        cur_tag = "R6";
        wr(0, A_MODE, 4'hF, 32'h0, w);
        wr(0, A_COUNT, 4'hF, 32'h0001_0005, w);
        wr(0, A_MODE, 4'hF, 32'h0000_1000, w);
        wait_until(w + 10);
        chk(expired == 1, "R6 flag without irq", expired, 1);
        wr(0, A_STATUS, 4'h1, 32'h1, w2);
        chk(expired == 0, "R6 clear again", expired, 0);

        // R3 zero divider
        cur_tag = "R3";
        wr(0, A_MODE, 4'hF, 32'h0, w);
        wr(0, A_COUNT, 4'hF, 32'h0000_0001, w);
        wr(0, A_MODE, 4'hF, 32'h0000_1100, w);
        exp_q.push_back(w + 65537);
        wait_until(w + 65536);
        chk(busy == 1, "R3 still counting", busy, 1);
        wait_until(w + 65540);
        chk(busy == 0, "R3 done after 65536", busy, 0);
        chk(exp_q.size() == 0, "R3 expiry seen", exp_q.size(), 0);
        wr(0, A_STATUS, 4'h1, 32'h1, w2);

        // R10 lock then release
        cur_tag = "R10";
        wr(0, A_MODE, 4'hF, 32'h0, w);
        wr(0, A_COUNT, 4'hF, 32'h0004_0005, w);
        wr(0, A_MODE, 4'hF, 32'h0000_9000, w);
        wr(0, A_MODE, 4'h3, 32'h0000_8000, wl);
        wait_until(wl + 2);
        chk(busy == 1, "R10 lone run clear ignored", busy, 1);
        wr(0, A_MODE, 4'h3, 32'h0, wx);
        wait_until(wx + 1);
        chk(busy == 0, "R10 full release stops", busy, 0);
        wait_until(w + 40);
        chk(rstreq == 0, "R10 no bite after release", rstreq, 0);

        // R9 service key, wrong key, R8 bite
        cur_tag = "R9";
        wr(0, A_MODE, 4'hF, 32'h0000_9000, w2);
        exp_rst = w2 + 21;
        wait_until(w2 + 8);
        wr(0, A_MODE, 4'h8, 32'hA500_0000, ws);
        exp_rst = ws + 21;
        wr(0, A_MODE, 4'h8, 32'h5A00_0000, wn);
        wait_until(ws + 20);
        chk(rstreq == 0, "R9 serviced, no bite yet", rstreq, 0);
        wait_until(ws + 22);
        chk(rstreq == 1, "R8 bite asserted", rstreq, 1);
        chk(expired == 0, "R8 no status flag", expired, 0);
        wr(0, A_MODE, 4'hF, 32'h0, w);
        wait_until(w + 5);
        chk(rstreq == 1, "R8 bite sticky", rstreq, 1);

        // R11 locked instance
        wr(1, A_COUNT, 4'hF, 32'h0001_0064, w);
        wr(1, A_MODE, 4'hF, 32'h0000_9000, wl);
        wr(1, A_MODE, 4'hF, 32'h0, w);
        wait_until(w + 2);
        chk(lk_busy == 1, "R11 release refused", lk_busy, 1);
        wait_until(wl + 105);
        chk(lk_rstreq == 1, "R11 bite despite release", lk_rstreq, 1);

        chk(exp_q.size() == 0, "R2 all expiries seen", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule